// File: doc/BRIEF.md
# Path Status Byte Monitor

This block looks at the path status byte that arrives once per received frame and does two things with it. The upper nibble carries a remote error figure. The block adds this figure to a 16-bit running total that stops at its maximum instead of wrapping. Software collects the total in latch-and-clear fashion: a latch request copies the running total into a holding register and starts a new accumulation period from zero.

Bits [3:1] of the same byte carry the remote defect indication. A provisioned select bit decides how these bits are read: either as a single defect flag or as an enhanced three-bit code. A new code is only adopted after it has persisted over several frames. The adopted code and its defect class stay in registers until a different code has persisted in the same way. When the pointer interpreter reports loss of pointer or path AIS, the frame's status byte is ignored entirely.

A two-state machine does the persistence filtering:
- `ST_SETTLED` holds the adopted code. A usable frame whose code differs from the adopted one moves it to `ST_PENDING` (transition *start candidate*).
- In `ST_PENDING`:
  - A repeat of the candidate advances a run count (*extend*).
  - A different usable code restarts the run with that code (*replace candidate*).
  - A frame that carries the adopted code returns the machine to `ST_SETTLED` (*abandon*).
  - The fifth consecutive repeat adopts the candidate and returns the machine to `ST_SETTLED` (*accept*).

Top module: `path_status_monitor`

## Requirements
- R1: On each accepted frame, the remote error field in status bits [7:4] is added to the running total when its value is 0 to 8. Values 9 to 15 add nothing.
- R2: The running total is 16 bits wide and stops at 65535 instead of wrapping.
- R3: A latch request copies the running total to `err_count` and restarts the total at zero. Between latch requests, `err_count` does not change.
- R4: When a latch request and a frame arrive in the same cycle, `err_count` receives the total from before that frame, and the frame's errors open the new period.
- R5: A frame with `ptr_lop` or `ptr_ais` high changes neither the running total nor the defect filter.
- R6: With `enh_sel` = 0 (single-bit mode), only status bit 3 is used. When bit 3 = 0 the code is 3'b000 and the class is 0 (none). When bit 3 = 1 the code is 3'b100 and the class is 1 (remote AIS / loss of pointer).
- R7: With `enh_sel` = 1 (enhanced mode), bits [3:1] are the code:
  - 001 gives class 0 (none).
  - 010 gives class 2 (payload mismatch / loss of cell delineation).
  - 101 gives class 1 (remote AIS / loss of pointer).
  - 110 gives class 3 (unequipped / trace mismatch).
- R8: A new code reaches `rdi_code` and `rdi_class` only after 5 consecutive usable frames carry it. It becomes visible on the cycle after the fifth such frame. A frame that carries the adopted code, or a different usable code, breaks the run.
- R9: In enhanced mode, the codes 000, 011, 100 and 111 are ignored: they neither change the outputs nor break a run in progress.
- R10: After reset, `err_count` = 0, `rdi_code` = 3'b000 and `rdi_class` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld | input | 1 | One-cycle strobe per frame; `status_byte` is valid |
| status_byte | input | 8 | Received path status byte |
| enh_sel | input | 1 | 0 = single-bit defect mode, 1 = enhanced mode |
| latch_req | input | 1 | Latch running total and restart it |
| ptr_lop | input | 1 | Pointer interpreter reports loss of pointer |
| ptr_ais | input | 1 | Pointer interpreter reports path AIS |
| err_count | output | 16 | Latched remote error total |
| rdi_code | output | 3 | Adopted remote defect code |
| rdi_class | output | 2 | Defect class of the adopted code |

## Verification
The bench drives the error field at both edges of the counted range (8 and 9) and pushes the total past 65535. A counter that masks badly or wraps would read wrong or small. It puts a latch request and a frame in the same cycle, where a wrong design credits the frame to the old period or loses it. It also stops defect runs at four frames, breaks them with the adopted code, and inserts unlisted enhanced codes in the middle of a run. A filter with an off-by-one count, a missing abandon path, or one that treats an unlisted code as a break adopts a code a frame early or late. Frames flagged by the pointer must leave both the total and the adopted code unchanged.

// File: rtl/psm_pkg.sv
package psm_pkg;

    // Defect class reported alongside the adopted code
    typedef enum logic [1:0] {
        DC_NONE     = 2'd0,
        DC_AIS_LOP  = 2'd1,
        DC_PLM_LCD  = 2'd2,
        DC_UNEQ_TIM = 2'd3
    } defect_class_e;

    // Persistence filter states
    typedef enum logic {
        ST_SETTLED = 1'b0,
        ST_PENDING = 1'b1
    } filt_state_e;

    // Enhanced-mode codes that carry meaning
    function automatic logic enh_code_listed(input logic [2:0] c);
        return (c == 3'b001) || (c == 3'b010) || (c == 3'b101) || (c == 3'b110);
    endfunction

    function automatic defect_class_e classify(input logic [2:0] c, input logic enh);
        defect_class_e r;
        if (!enh) begin
            r = c[2] ? DC_AIS_LOP : DC_NONE;
        end else begin
            unique case (c)
                3'b010:  r = DC_PLM_LCD;
                3'b101:  r = DC_AIS_LOP;
                3'b110:  r = DC_UNEQ_TIM;
                default: r = DC_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/psm_rei_accum.sv
module psm_rei_accum #(
    parameter int CNT_W   = 16,
    parameter int REI_W   = 4,
    parameter int REI_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_vld,
    input  logic             mon_block,
    input  logic [REI_W-1:0] rei,
    input  logic             latch_req,
    output logic [CNT_W-1:0] held
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] acc_q, held_q;
    logic [REI_W-1:0] inc;
    logic [SUM_W-1:0] sum;
    logic             upd;

    always_comb begin
        upd = frame_vld && !mon_block;
        inc = (rei <= REI_W'(REI_MAX)) ? rei : '0;
        sum = {1'b0, acc_q} + SUM_W'(inc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            held_q <= '0;
        end else if (latch_req) begin
            held_q <= acc_q;
            acc_q  <= upd ? CNT_W'(inc) : '0;
        end else if (upd) begin
            acc_q  <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        end
    end

    assign held = held_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_req |=> acc_q >= $past(acc_q)); // R2
    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        latch_req |=> held_q == $past(acc_q)); // R3
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_req |=> $stable(held_q)); // R3
    AST_PTR_BLOCK_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && mon_block && !latch_req) |=> $stable(acc_q)); // R5

endmodule

// File: rtl/psm_rdi_filter.sv
module psm_rdi_filter
    import psm_pkg::*;
#(
    parameter int PERSIST = 5   // must be 2 or more
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_vld,
    input  logic          mon_block,
    input  logic          enh_mode,
    input  logic [2:0]    rdi_bits,
    output logic [2:0]    code,
    output defect_class_e dclass
);
    localparam int CW = $clog2(PERSIST + 1);
    localparam logic [CW-1:0] LAST = CW'(PERSIST - 1);

    filt_state_e   state_q, state_d;
    logic [2:0]    code_q, code_d, cand_q, cand_d, cand;
    logic [CW-1:0] cnt_q, cnt_d;
    defect_class_e class_q, class_d;
    logic          take;

    always_comb begin
        cand = enh_mode ? rdi_bits : {rdi_bits[2], 2'b00};
        take = frame_vld && !mon_block && (!enh_mode || enh_code_listed(rdi_bits));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLED;
            code_q  <= 3'b000;
            class_q <= DC_NONE;
            cand_q  <= 3'b000;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            class_q <= class_d;
            cand_q  <= cand_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        class_d = class_q;
        cand_d  = cand_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_SETTLED: begin
                if (take && cand != code_q) begin       // start candidate
                    state_d = ST_PENDING;
                    cand_d  = cand;
                    cnt_d   = CW'(1);
                end
            end
            ST_PENDING: begin
                if (take) begin
                    if (cand == code_q) begin           // abandon
                        state_d = ST_SETTLED;
                        cnt_d   = '0;
                    end else if (cand == cand_q) begin
                        if (cnt_q == LAST) begin        // accept
                            state_d = ST_SETTLED;
                            code_d  = cand;
                            class_d = classify(cand, enh_mode);
                            cnt_d   = '0;
                        end else begin                  // extend
                            cnt_d   = cnt_q + CW'(1);
                        end
                    end else begin                      // replace candidate
                        cand_d  = cand;
                        cnt_d   = CW'(1);
                    end
                end
            end
            default: state_d = ST_SETTLED;
        endcase
    end

    // Outputs
    assign code   = code_q;
    assign dclass = class_q;

    AST_SETTLED_HOLDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLED) |=> $stable(code_q)); // R8
    AST_PTR_BLOCK_RDI: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && mon_block) |=> ($stable(code_q) && $stable(cnt_q))); // R5
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R8
    AST_UNLISTED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && enh_mode && !enh_code_listed(rdi_bits)) |=> ($stable(code_q) && $stable(cnt_q))); // R9

endmodule

// File: rtl/path_status_monitor.sv
module path_status_monitor
    import psm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int REI_MAX = 8,
    parameter int PERSIST = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_vld,
    input  logic [7:0]       status_byte,
    input  logic             enh_sel,
    input  logic             latch_req,
    input  logic             ptr_lop,
    input  logic             ptr_ais,
    output logic [CNT_W-1:0] err_count,
    output logic [2:0]       rdi_code,
    output logic [1:0]       rdi_class
);
    logic          mon_block;
    logic          unused_spare;
    defect_class_e dclass;

    assign mon_block    = ptr_lop || ptr_ais;
    assign unused_spare = status_byte[0];

    psm_rei_accum #(
        .CNT_W   (CNT_W),
        .REI_W   (4),
        .REI_MAX (REI_MAX)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .mon_block (mon_block),
        .rei       (status_byte[7:4]),
        .latch_req (latch_req),
        .held      (err_count)
    );

    psm_rdi_filter #(
        .PERSIST (PERSIST)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .mon_block (mon_block),
        .enh_mode  (enh_sel),
        .rdi_bits  (status_byte[3:1]),
        .code      (rdi_code),
        .dclass    (dclass)
    );

    assign rdi_class = dclass;

    AST_CLASS_FOLLOWS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdi_code == 3'b000) |-> (rdi_class == 2'd0)); // R6

endmodule

// File: tb/path_status_monitor_bench.sv
`timescale 1ns/1ps
module path_status_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_vld = 1'b0;
    logic [7:0]  status_byte = 8'h00;
    logic        enh_sel = 1'b0;
    logic        latch_req = 1'b0;
    logic        ptr_lop = 1'b0;
    logic        ptr_ais = 1'b0;
    logic [15:0] err_count;
    logic [2:0]  rdi_code;
    logic [1:0]  rdi_class;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    path_status_monitor u_path_status_monitor (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .status_byte(status_byte),
        .enh_sel(enh_sel), .latch_req(latch_req), .ptr_lop(ptr_lop), .ptr_ais(ptr_ais),
        .err_count(err_count), .rdi_code(rdi_code), .rdi_class(rdi_class)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // n consecutive frames carrying byte b; returns at a negedge after the last edge
    task automatic frames(input logic [7:0] b, input int n);
        @(negedge clk);
        frame_vld   = 1'b1;
        status_byte = b;
        repeat (n) @(negedge clk);
        frame_vld   = 1'b0;
    endtask

    task automatic do_latch();
        @(negedge clk);
        latch_req = 1'b1;
        @(negedge clk);
        latch_req = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 err_count", err_count, 0);
        check("R10 rdi_code", rdi_code, 0);
        check("R10 rdi_class", rdi_class, 0);
    endtask

    task automatic t_rei_range();
        frames(8'h30, 1);
        frames(8'h80, 1);
        frames(8'h90, 1);
        frames(8'hF0, 1);
        frames(8'h10, 1);
        do_latch();
        check("R1 sum with 9 and 15 ignored", err_count, 12);
    endtask

    task automatic t_latch_clear();
        do_latch();
        check("R3 restart from zero", err_count, 0);
        frames(8'h50, 2);
        repeat (4) @(negedge clk);
        check("R3 held stable between latches", err_count, 0);
        do_latch();
        check("R3 latched value", err_count, 10);
    endtask

    task automatic t_same_cycle();
        frames(8'h40, 1);
        @(negedge clk);
        frame_vld = 1'b1; status_byte = 8'h70; latch_req = 1'b1;
        @(negedge clk);
        frame_vld = 1'b0; latch_req = 1'b0;
        check("R4 old period excludes frame", err_count, 4);
        do_latch();
        check("R4 frame in new period", err_count, 7);
    endtask

    task automatic t_ptr_block();
        ptr_ais = 1'b1;
        frames(8'h88, 6);
        ptr_ais = 1'b0;
        ptr_lop = 1'b1;
        frames(8'h88, 6);
        ptr_lop = 1'b0;
        check("R5 defect code unchanged", rdi_code, 0);
        do_latch();
        check("R5 errors not counted", err_count, 0);
    endtask

    task automatic t_saturate();
        frames(8'h80, 8200);
        do_latch();
        check("R2 saturates at 65535", err_count, 65535);
        do_latch();
        check("R2 restart after saturation", err_count, 0);
    endtask

    task automatic t_single();
        enh_sel = 1'b0;
        frames(8'h0E, 4);
        check("R8 four frames not enough", rdi_code, 0);
        frames(8'h0E, 1);
        check("R6 single-bit set code", rdi_code, 3'b100);
        check("R6 single-bit set class", rdi_class, 1);
        frames(8'h06, 5);
        check("R6 single-bit clear code", rdi_code, 3'b000);
        check("R6 single-bit clear class", rdi_class, 0);
    endtask

    task automatic t_enhanced();
        enh_sel = 1'b1;
        frames(8'h04, 5);
        check("R7 code 010", rdi_code, 3'b010);
        check("R7 class of 010", rdi_class, 2);
        frames(8'h0A, 5);
        check("R7 class of 101", rdi_class, 1);
        frames(8'h0C, 5);
        check("R7 class of 110", rdi_class, 3);
        frames(8'h02, 5);
        check("R7 code 001", rdi_code, 3'b001);
        check("R7 class of 001", rdi_class, 0);
    endtask

    task automatic t_unlisted();
        frames(8'h04, 3);
        frames(8'h0E, 1);
        frames(8'h08, 1);
        check("R9 unlisted code ignored", rdi_code, 3'b001);
        frames(8'h04, 2);
        check("R9 run survives unlisted codes", rdi_code, 3'b010);
    endtask

    task automatic t_interrupt();
        frames(8'h0A, 4);
        frames(8'h04, 1);
        frames(8'h0A, 4);
        check("R8 run broken by adopted code", rdi_code, 3'b010);
        frames(8'h0C, 2);
        frames(8'h0A, 4);
        check("R8 run broken by other code", rdi_code, 3'b010);
        frames(8'h0A, 1);
        check("R8 adopted on fifth frame", rdi_code, 3'b101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rei_range();
        t_latch_clear();
        t_same_cycle();
        t_ptr_block();
        t_saturate();
        t_single();
        t_enhanced();
        t_unlisted();
        t_interrupt();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule